// File: doc/BRIEF.md
# Interleaved Frame Capture with Window and Sync Check

This block sits behind the digitizer of one fibre channel. The channel carries frames from two front-end readout chips at one 10-bit sample per clock. Each frame has a 24-word header followed by 256 data words. The block watches the sample stream for the start of a frame. It accepts a frame only when the frame starts inside a time window that is programmed relative to a trigger pulse. From the header it decodes a pipeline address and two error bits.

The data words of the two chips arrive interleaved, and within each chip they arrive in a scrambled strip order. The block writes every word straight into its strip position in a two-chip buffer. When the frame is complete it checks the decoded pipeline address against a reference address supplied for the same trigger. That reference may arrive before or after the frame; if it is late, the check waits for it. After the check, the buffer is streamed out in strip order, one word per cycle.

Top module: `mux_frame_capture`

## Requirements
- R1: While `rst_n` is low, `frm_valid_o`, `out_of_sync_o`, `oow_o` and `rd_valid_o` are all 0.
- R2: A one-cycle `trig_i` arms the window. The cycle after the trigger is offset 0. The window is open at offsets `win_lo_i` through `win_hi_i` inclusive, and it closes for good after offset `win_hi_i` until the next trigger.
- R3: A frame start is the sample in an idle cycle for which `sample_i >= thr_i`. A start seen while the window is open is accepted as header word 0. Header words 0..23 then take 24 cycles, and data words 0..255 take the next 256 cycles.
- R4: A header word reads as bit 1 when `sample_i >= thr_i` and as bit 0 otherwise. Header words 3..10 give the 8-bit pipeline address with the most significant bit first. Word 11 gives error bit 1 and word 12 gives error bit 0. `addr_o` and `err_o` keep these values through the readout.
- R5: A frame start seen while the window is closed gives a one-cycle `oow_o` in that same cycle. No sample of the 279 cycles that follow can start a frame or raise `oow_o`.
- R6: Data word j belongs to chip j[0]. Its strip is the 7-bit bit-reversal of j>>1. It is read out at index chip*128 + strip.
- R7: `frm_valid_o` pulses once per accepted frame. It fires in the first cycle, at or after the cycle following data word 255, in which a reference address is available. `out_of_sync_o` is high in that cycle exactly when the decoded address differs from the reference.
- R8: A reference (`ref_valid_i` with `ref_addr_i`) that arrives before it is needed is held until a frame uses it. A reference that arrives while the frame is waiting resolves the check in its own arrival cycle.
- R9: Readout begins in the cycle after `frm_valid_o`. It runs for 256 consecutive cycles with `rd_idx_o` going 0 to 255. No frame start or `oow_o` is recognised from the end of the frame until the readout has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 10 | Digitized sample stream |
| thr_i | input | 10 | Threshold for frame start and header bits |
| trig_i | input | 1 | Trigger pulse that arms the window |
| win_lo_i | input | 12 | First open offset after the trigger |
| win_hi_i | input | 12 | Last open offset after the trigger |
| ref_valid_i | input | 1 | Reference address strobe |
| ref_addr_i | input | 8 | Reference pipeline address |
| frm_valid_o | output | 1 | Frame complete and checked |
| addr_o | output | 8 | Decoded pipeline address |
| err_o | output | 2 | Decoded error bits |
| out_of_sync_o | output | 1 | Address differs from reference |
| oow_o | output | 1 | Frame start outside the window |
| rd_valid_o | output | 1 | Readout word valid |
| rd_idx_o | output | 8 | Readout index, chip*128 + strip |
| rd_data_o | output | 10 | Readout sample |

## Verification
The assertions assume that trigger pulses, reference strobes and frame starts are spaced so that each accepted frame is paired with exactly one reference. They also assume that a reference never arrives in the same cycle as a check that consumes an older held reference. The stimulus places every frame, trigger and reference at planned cycles and leaves the channel at zero between frames. References are issued only for frames that will be accepted, so none is left over. The bench also deliberately raises samples during a rejected frame's dead time and during a readout while the window is open, to show that those samples are ignored.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_WAIT,
    ST_READ,
    ST_SKIP
  } mfc_state_e;
endpackage

// File: rtl/mfc_window.sv
module mfc_window #(
  parameter int WIN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [WIN_W-1:0] lo_i,
  input  logic [WIN_W-1:0] hi_i,
  output logic             open_o
);
  logic [WIN_W-1:0] cnt_q, cnt_d;
  logic             arm_q, arm_d;

  always_comb begin
    cnt_d = cnt_q;
    arm_d = arm_q;
    if (trig_i) begin
      cnt_d = '0;
      arm_d = 1'b1;
    end else if (arm_q) begin
      if (cnt_q == hi_i) arm_d = 1'b0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      arm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      arm_q <= arm_d;
    end
  end

  assign open_o = arm_q && (cnt_q >= lo_i) && (cnt_q <= hi_i);
endmodule

// File: rtl/mfc_hdr_capture.sv
module mfc_hdr_capture #(
  parameter int PA_W   = 8,
  parameter int CNT_W  = 9,
  parameter int PA_POS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] word_i,
  input  logic             bit_i,
  output logic [PA_W-1:0]  pa_o,
  output logic [1:0]       err_o
);
  localparam logic [CNT_W-1:0] PA_FIRST = CNT_W'(PA_POS);
  localparam logic [CNT_W-1:0] PA_LAST  = CNT_W'(PA_POS + PA_W - 1);
  localparam logic [CNT_W-1:0] ERR_HI   = CNT_W'(PA_POS + PA_W);
  localparam logic [CNT_W-1:0] ERR_LO   = CNT_W'(PA_POS + PA_W + 1);

  logic [PA_W-1:0] pa_q, pa_d;
  logic [1:0]      err_q, err_d;

  always_comb begin
    pa_d  = pa_q;
    err_d = err_q;
    if (en_i) begin
      if (word_i >= PA_FIRST && word_i <= PA_LAST) pa_d = {pa_q[PA_W-2:0], bit_i};
      if (word_i == ERR_HI) err_d[1] = bit_i;
      if (word_i == ERR_LO) err_d[0] = bit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q  <= '0;
      err_q <= '0;
    end else begin
      pa_q  <= pa_d;
      err_q <= err_d;
    end
  end

  assign pa_o  = pa_q;
  assign err_o = err_q;
endmodule

// File: rtl/mfc_reorder_buf.sv
module mfc_reorder_buf #(
  parameter int SMP_W  = 10,
  parameter int STRIPS = 128,
  localparam int IDX_W  = $clog2(STRIPS),
  localparam int DIDX_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [DIDX_W-1:0] seq_i,
  input  logic [SMP_W-1:0]  wdata_i,
  input  logic [DIDX_W-1:0] rd_addr_i,
  output logic [SMP_W-1:0]  rdata_o
);
  logic [SMP_W-1:0]  mem_q [2*STRIPS];
  logic [IDX_W-1:0]  pos;
  logic [IDX_W-1:0]  strip;
  logic [DIDX_W-1:0] wr_addr;

  assign pos = seq_i[DIDX_W-1:1];

  for (genvar b = 0; b < IDX_W; b++) begin : g_rev
    assign strip[b] = pos[IDX_W-1-b];
  end

  assign wr_addr = {seq_i[0], strip};

  always_ff @(posedge clk) begin
    if (we_i) mem_q[wr_addr] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_addr_i];
endmodule

// File: rtl/mux_frame_capture.sv
module mux_frame_capture #(
  parameter int SMP_W   = 10,
  parameter int PA_W    = 8,
  parameter int HDR_LEN = 24,
  parameter int STRIPS  = 128,
  parameter int WIN_W   = 12,
  parameter int PA_POS  = 3,
  localparam int DIDX_W = $clog2(STRIPS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SMP_W-1:0]  sample_i,
  input  logic [SMP_W-1:0]  thr_i,
  input  logic              trig_i,
  input  logic [WIN_W-1:0]  win_lo_i,
  input  logic [WIN_W-1:0]  win_hi_i,
  input  logic              ref_valid_i,
  input  logic [PA_W-1:0]   ref_addr_i,
  output logic              frm_valid_o,
  output logic [PA_W-1:0]   addr_o,
  output logic [1:0]        err_o,
  output logic              out_of_sync_o,
  output logic              oow_o,
  output logic              rd_valid_o,
  output logic [DIDX_W-1:0] rd_idx_o,
  output logic [SMP_W-1:0]  rd_data_o
);
  import mfc_pkg::*;

  localparam int DATA_LEN = 2 * STRIPS;
  localparam int FRM_LEN  = HDR_LEN + DATA_LEN;
  localparam int CNT_W    = $clog2(FRM_LEN);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_LEN - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_LEN - 1);
  localparam logic [CNT_W-1:0] FRM_LAST  = CNT_W'(FRM_LEN - 1);

  mfc_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ref_held_q, ref_held_d;
  logic [PA_W-1:0]  ref_q, ref_d;
  logic             above, win_open, ref_avail, fire;
  logic [PA_W-1:0]  ref_cmp;

  assign above     = sample_i >= thr_i;
  assign ref_avail = ref_held_q || ref_valid_i;
  assign ref_cmp   = ref_held_q ? ref_q : ref_addr_i;
  assign fire      = (st_q == ST_WAIT) && ref_avail;

  mfc_window #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i),
    .lo_i(win_lo_i), .hi_i(win_hi_i), .open_o(win_open)
  );

  mfc_hdr_capture #(.PA_W(PA_W), .CNT_W(CNT_W), .PA_POS(PA_POS)) u_hdr (
    .clk(clk), .rst_n(rst_n), .en_i(st_q == ST_HDR), .word_i(cnt_q),
    .bit_i(above), .pa_o(addr_o), .err_o(err_o)
  );

  mfc_reorder_buf #(.SMP_W(SMP_W), .STRIPS(STRIPS)) u_buf (
    .clk(clk), .we_i(st_q == ST_DATA), .seq_i(cnt_q[DIDX_W-1:0]),
    .wdata_i(sample_i), .rd_addr_i(cnt_q[DIDX_W-1:0]), .rdata_o(rd_data_o)
  );

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: if (above) begin
        st_d  = win_open ? ST_HDR : ST_SKIP;
        cnt_d = CNT_W'(1);
      end
      ST_HDR: if (cnt_q == HDR_LAST) begin
        st_d  = ST_DATA;
        cnt_d = '0;
      end else cnt_d = cnt_q + 1'b1;
      ST_DATA: if (cnt_q == DATA_LAST) begin
        st_d  = ST_WAIT;
        cnt_d = '0;
      end else cnt_d = cnt_q + 1'b1;
      ST_WAIT: if (ref_avail) begin
        st_d  = ST_READ;
        cnt_d = '0;
      end
      ST_READ: if (cnt_q == DATA_LAST) st_d = ST_IDLE;
               else cnt_d = cnt_q + 1'b1;
      ST_SKIP: if (cnt_q == FRM_LAST) st_d = ST_IDLE;
               else cnt_d = cnt_q + 1'b1;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ref_held_d = ref_held_q;
    ref_d      = ref_q;
    if (fire) begin
      ref_held_d = 1'b0;
    end else if (ref_valid_i) begin
      ref_held_d = 1'b1;
      ref_d      = ref_addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      ref_held_q <= 1'b0;
      ref_q      <= '0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      ref_held_q <= ref_held_d;
      ref_q      <= ref_d;
    end
  end

  assign frm_valid_o   = fire;
  assign out_of_sync_o = fire && (addr_o != ref_cmp);
  assign oow_o         = (st_q == ST_IDLE) && above && !win_open;
  assign rd_valid_o    = st_q == ST_READ;
  assign rd_idx_o      = cnt_q[DIDX_W-1:0];
endmodule

// File: rtl/mfc_checker.sv
module mfc_checker #(
  parameter int PA_W   = 8,
  parameter int DIDX_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_valid,
  input logic              out_of_sync,
  input logic              oow,
  input logic              rd_valid,
  input logic [DIDX_W-1:0] rd_idx,
  input logic [PA_W-1:0]   addr,
  input logic [1:0]        err,
  input logic              win_open
);
  localparam logic [DIDX_W-1:0] LAST = '1;

  p_oow_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    oow |-> !win_open);

  p_sync_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_sync |-> frm_valid);

  p_read_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> rd_valid && rd_idx == '0);

  p_read_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_idx != LAST |=> rd_valid && rd_idx == DIDX_W'($past(rd_idx) + 1'b1));

  p_read_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_idx == LAST |=> !rd_valid);

  p_quiet_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !oow && !frm_valid);

  p_hdr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $stable(addr) && $stable(err));
endmodule

bind mux_frame_capture mfc_checker #(.PA_W(PA_W), .DIDX_W(DIDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid_o), .out_of_sync(out_of_sync_o),
  .oow(oow_o), .rd_valid(rd_valid_o), .rd_idx(rd_idx_o), .addr(addr_o),
  .err(err_o), .win_open(win_open)
);

// File: tb/mux_frame_capture_tb.sv
module mux_frame_capture_tb;
  localparam int LO = 20;
  localparam int HI = 40;
  localparam int THR = 512;
  localparam int END_CYC = 4600;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] sample_i, thr_i;
  logic       trig_i;
  logic [11:0] win_lo_i, win_hi_i;
  logic       ref_valid_i;
  logic [7:0] ref_addr_i;
  logic       frm_valid_o, out_of_sync_o, oow_o, rd_valid_o;
  logic [7:0] addr_o, rd_idx_o;
  logic [1:0] err_o;
  logic [9:0] rd_data_o;

  always #2 clk = ~clk;

  mux_frame_capture u_dut (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .thr_i(thr_i), .trig_i(trig_i),
    .win_lo_i(win_lo_i), .win_hi_i(win_hi_i), .ref_valid_i(ref_valid_i),
    .ref_addr_i(ref_addr_i), .frm_valid_o(frm_valid_o), .addr_o(addr_o),
    .err_o(err_o), .out_of_sync_o(out_of_sync_o), .oow_o(oow_o),
    .rd_valid_o(rd_valid_o), .rd_idx_o(rd_idx_o), .rd_data_o(rd_data_o)
  );

  int s_smp[int];
  bit s_trig[int];
  bit s_refv[int];
  int s_refa[int];
  bit e_frm[int];
  int e_oos[int];
  int e_addr[int];
  int e_err[int];
  bit e_oow[int];
  int e_rdk[int];
  int e_rdd[int];

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  function automatic int pat(input int seed, input int j);
    return (seed * 97 + j * 29 + 5) % 1024;
  endfunction

  function automatic int rev7(input int v);
    int r = 0;
    for (int b = 0; b < 7; b++) if (v & (1 << b)) r |= 1 << (6 - b);
    return r;
  endfunction

  // Behavioural model of one frame: places stimulus and the expected port activity
  task automatic add_frame(input int t, input int s, input int r, input int pa,
                           input int refa, input int err, input int seed);
    bit acc;
    int f;
    acc = (t >= 0) && (s >= t + 1 + LO) && (s <= t + 1 + HI);
    if (t >= 0) s_trig[t] = 1;
    for (int w = 0; w < 24; w++) begin
      int v = 100;
      if (w < 3) v = 900;
      else if (w <= 10) v = ((pa >> (10 - w)) & 1) ? 800 : 100;
      else if (w == 11) v = ((err >> 1) & 1) ? 800 : 100;
      else if (w == 12) v = (err & 1) ? 800 : 100;
      s_smp[s + w] = v;
    end
    for (int j = 0; j < 256; j++) s_smp[s + 24 + j] = pat(seed, j);
    if (r >= 0) begin
      s_refv[r] = 1;
      s_refa[r] = refa;
    end
    if (acc) begin
      f = (r > s + 280) ? r : s + 280;
      e_frm[f] = 1;
      e_oos[f] = (pa != refa) ? 1 : 0;
      e_addr[f] = pa;
      e_err[f] = err;
      for (int k = 0; k < 256; k++) begin
        e_rdk[f + 1 + k] = k;
        e_rdd[f + 1 + k] = pat(seed, 2 * rev7(k % 128) + k / 128);
      end
    end else begin
      e_oow[s] = 1;
    end
  endtask

  task automatic drive();
    sample_i    = s_smp.exists(cyc) ? 10'(s_smp[cyc]) : 10'd0;
    trig_i      = s_trig.exists(cyc);
    ref_valid_i = s_refv.exists(cyc);
    ref_addr_i  = s_refv.exists(cyc) ? 8'(s_refa[cyc]) : 8'd0;
  endtask

  task automatic compare();
    bit f = e_frm.exists(cyc);
    bit o = e_oow.exists(cyc);
    bit rv = e_rdk.exists(cyc);
    chk("R3 R7 frm_valid", int'(frm_valid_o), int'(f));
    chk("R2 R5 oow", int'(oow_o), int'(o));
    chk("R9 rd_valid", int'(rd_valid_o), int'(rv));
    if (f) begin
      chk("R7 R8 out_of_sync", int'(out_of_sync_o), e_oos[cyc]);
      chk("R4 addr", int'(addr_o), e_addr[cyc]);
      chk("R4 err", int'(err_o), e_err[cyc]);
    end else begin
      chk("R7 out_of_sync idle", int'(out_of_sync_o), 0);
    end
    if (rv) begin
      chk("R9 rd_idx", int'(rd_idx_o), e_rdk[cyc]);
      chk("R6 rd_data", int'(rd_data_o), e_rdd[cyc]);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    thr_i = 10'(THR);
    win_lo_i = 12'(LO);
    win_hi_i = 12'(HI);
    sample_i = '0; trig_i = 0; ref_valid_i = 0; ref_addr_i = '0;

    // early reference held (R8), matching address
    add_frame(10, 40, 100, 8'hA5, 8'hA5, 2'b00, 1);
    // late reference resolves in its own cycle, mismatch (R8, R7)
    add_frame(600, 640, 1000, 8'h3C, 8'h3D, 2'b11, 2);
    // trigger and a high sample during the readout: ignored (R9)
    s_trig[1080] = 1;
    s_smp[1110] = 900;
    // start before the window opens (R2, R5)
    add_frame(1300, 1310, -1, 8'h11, 8'h11, 2'b00, 3);
    // no trigger at all (R5)
    add_frame(-1, 1700, -1, 8'h22, 8'h22, 2'b00, 4);
    // start at the last open offset (R2), error bit 1
    add_frame(2100, 2141, 2200, 8'h5A, 8'h5A, 2'b10, 5);
    // start at the first open offset, reference exactly when data ends (R8)
    add_frame(2800, 2821, 3101, 8'h81, 8'h81, 2'b01, 6);
    // one cycle before the window opens (R2)
    add_frame(3500, 3520, -1, 8'h33, 8'h33, 2'b00, 7);
    // reference before the trigger, all-ones against zero (R7)
    add_frame(3900, 3930, 3850, 8'hFF, 8'h00, 2'b00, 8);

    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 reset frm_valid", int'(frm_valid_o), 0);
      chk("R1 reset oow", int'(oow_o), 0);
      chk("R1 reset rd_valid", int'(rd_valid_o), 0);
      chk("R1 reset out_of_sync", int'(out_of_sync_o), 0);
    end
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    cyc = 0;
    while (cyc <= END_CYC) begin
      drive();
      @(negedge clk);
      compare();
      @(posedge clk);
      #1;
      cyc++;
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule